// File: doc/BRIEF.md
# Watermark-Interrupt UART

A register-mapped serial port with a 32-bit bus side. Transmit and receive each have an 8-entry byte queue. A serializer sends frames with 8 data bits, no parity, LSB first, and one or two stop bits. A deserializer recovers incoming frames. Both sides run at a bit period of (divisor + 1) clock cycles, set through a divisor register.

The bus port is synchronous and uses word addresses, a write strobe and a read strobe. Read data is combinational from the address. A read takes effect at the clock edge where the read strobe is high. The queue status sits in bit 31 of the data registers:
- On the transmit data word, bit 31 means the queue is full.
- On the receive data word, bit 31 means the queue is empty.

Reading the receive data word removes the byte it returns.

Each direction has a 3-bit occupancy watermark that drives a pending level. The single interrupt output is the OR of the enabled pending levels.

Top module: `wm_uart`

## Requirements
- R1: After reset the serial output is high, `irq` is low, and the transmit control, receive control and interrupt enable words read 0. The receive data word reads 0x8000_0000.
- R2: Word address 0 is transmit data. With transmit enable (transmit control bit 0) set, each queued byte goes out in FIFO order, with a bit period of divisor+1 cycles. Each frame is a low start bit, then 8 data bits LSB first, then a high stop bit. The line is high while nothing is being sent.
- R3: Reading word 0 returns bit 31 set while 8 bytes are queued. A write to word 0 while the queue is full is dropped. While transmit enable is clear, queued bytes are held and not sent.
- R4: Transmit control bit 1 set makes every frame end with two high stop bits before the next start bit.
- R5: Word address 1 is receive data. When receive enable (receive control bit 0) is set, a received frame with a high stop bit is queued. A read returns the oldest byte in bits 7:0 with bit 31 clear, and removes it. A read while the queue is empty returns 0x8000_0000 and changes nothing.
- R6: Once 8 bytes are waiting, further received bytes are discarded. The 8 stored bytes read back intact and in order.
- R7: Pending (word 5) bit 1 is high while the receive count exceeds the receive watermark (receive control bits 18:16). Pending bit 0 is high while the transmit count is below the transmit watermark (transmit control bits 18:16). `irq` is the OR of pending bits ANDed with the interrupt enable bits (word 4, same bit positions).
- R8: A low pulse on the serial input that is high again at mid-bit is not taken as a start bit, and no byte is received.
- R9: While receive enable is clear, incoming frames are ignored. Word 6 holds the divisor. Words 2 and 3 hold the transmit and receive control words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Word address of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops the receive queue on word 1 |
| rdata | output | 32 | Read data for `addr` |
| tx | output | 1 | Serial output |
| rx | input | 1 | Serial input |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with the default queue depth of 8 and divisor width of 16. It programs a divisor of 3, so each bit lasts 4 cycles. This short bit period lets every frame, back-to-back bursts of nine frames, and mid-bit glitch rejection fit in a few thousand cycles. With a depth of 8, both the full and the overflow boundaries are reached with nine bytes. The 3-bit watermark field can then be tested on both sides of its comparison.

// File: rtl/wm_uart.sv
module wm_uart #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic        rd_en,
  output logic [31:0] rdata,
  output logic        tx,
  input  logic        rx,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_en, tx_two, rx_en;
  logic [2:0] tx_wm, rx_wm;
  logic [1:0] ie;
  logic [DIV_W-1:0] div;

  logic tx_busy;
  logic [9:0] tx_sh;
  logic [3:0] tx_left;
  logic [DIV_W-1:0] tx_bcnt;

  logic [2:0] rx_q;
  logic [1:0] rx_ph;
  logic [2:0] rx_bits;
  logic [7:0] rx_sh;
  logic [DIV_W-1:0] rx_bcnt;

  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_empty = rx_cnt == '0;
  wire tx_push  = wr_en && addr == 3'd0 && !tx_full;
  wire tx_pop   = !tx_busy && tx_en && tx_cnt != '0;
  wire rx_pop   = rd_en && addr == 3'd1 && !rx_empty;
  wire rx_s     = rx_q[1];
  wire rx_tick  = rx_bcnt == '0;
  wire rx_push  = rx_ph == 2'd3 && rx_tick && rx_s && rx_cnt != CW'(DEPTH);
  wire tx_pend  = tx_cnt < CW'(tx_wm);
  wire rx_pend  = rx_cnt > CW'(rx_wm);

  assign tx  = !tx_busy || tx_sh[0];
  assign irq = |(ie & {rx_pend, tx_pend});

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0: rdata[31] = tx_full;
      3'd1: rdata = rx_empty ? 32'h8000_0000 : {24'd0, rxm[rx_rp]};
      3'd2: rdata = {13'd0, tx_wm, 14'd0, tx_two, tx_en};
      3'd3: rdata = {13'd0, rx_wm, 15'd0, rx_en};
      3'd4: rdata[1:0] = ie;
      3'd5: rdata[1:0] = {rx_pend, tx_pend};
      3'd6: rdata[DIV_W-1:0] = div;
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= wdata[7:0];
    if (rx_push) rxm[rx_wp] <= rx_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      tx_en <= 1'b0; tx_two <= 1'b0; tx_wm <= '0;
      rx_en <= 1'b0; rx_wm <= '0; ie <= '0; div <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      if (wr_en) begin
        case (addr)
          3'd2: begin tx_en <= wdata[0]; tx_two <= wdata[1]; tx_wm <= wdata[18:16]; end
          3'd3: begin rx_en <= wdata[0]; rx_wm <= wdata[18:16]; end
          3'd4: ie <= wdata[1:0];
          3'd6: div <= wdata[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_sh <= '1; tx_left <= '0; tx_bcnt <= '0;
    end else if (!tx_busy) begin
      if (tx_pop) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, txm[tx_rp], 1'b0};
        tx_left <= tx_two ? 4'd11 : 4'd10;
        tx_bcnt <= div;
      end
    end else if (tx_bcnt != '0) begin
      tx_bcnt <= tx_bcnt - 1'b1;
    end else begin
      tx_bcnt <= div;
      tx_sh   <= {1'b1, tx_sh[9:1]};
      tx_left <= tx_left - 1'b1;
      if (tx_left == 4'd1) tx_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= '1; rx_ph <= '0; rx_bits <= '0; rx_sh <= '0; rx_bcnt <= '0;
    end else begin
      rx_q <= {rx_q[1:0], rx};
      if (rx_ph == 2'd0) begin
        if (rx_en && rx_q[2] && !rx_s) begin
          rx_ph   <= 2'd1;
          rx_bcnt <= div >> 1;
        end
      end else if (!rx_tick) begin
        rx_bcnt <= rx_bcnt - 1'b1;
      end else begin
        rx_bcnt <= div;
        case (rx_ph)
          2'd1: begin rx_ph <= rx_s ? 2'd0 : 2'd2; rx_bits <= '0; end
          2'd2: begin
            rx_sh   <= {rx_s, rx_sh[7:1]};
            rx_bits <= rx_bits + 1'b1;
            if (rx_bits == 3'd7) rx_ph <= 2'd3;
          end
          default: rx_ph <= 2'd0;
        endcase
      end
    end
  end
endmodule

// File: rtl/wm_uart_chk.sv
module wm_uart_chk #(
  parameter int DEPTH = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    addr,
  input logic          tx,
  input logic          irq,
  input logic          tx_busy,
  input logic          tx_pop,
  input logic          rx_push,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [1:0]    ie,
  input logic [2:0]    tx_wm,
  input logic [2:0]    rx_wm
);
  p_idle_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> tx);
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && tx_cnt == CW'(DEPTH) && !tx_pop) |=> tx_cnt == CW'(DEPTH));
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd1 && rx_cnt == '0 && !rx_push) |=> rx_cnt == '0);
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH) && tx_cnt <= CW'(DEPTH));
  p_rx_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie[1] && rx_cnt > CW'(rx_wm)) |-> irq);
  p_tx_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ie[0] && tx_cnt < CW'(tx_wm)) |-> irq);
  p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ie[0] || tx_cnt >= CW'(tx_wm)) && (!ie[1] || rx_cnt <= CW'(rx_wm))) |-> !irq);
endmodule

bind wm_uart wm_uart_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (.*);

// File: tb/wm_uart_bench.sv
`timescale 1ns/100ps
module wm_uart_bench;
  localparam int BIT = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, rx = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tx, irq;
  int checks = 0, errors = 0;
  logic two_stop = 1'b0;
  logic [7:0] expq [$];

  wm_uart u_wm_uart (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .tx(tx), .rx(rx), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic put_tx(input logic [7:0] b, input logic keep);
    wr(3'd0, {24'd0, b});
    if (keep) expq.push_back(b);
  endtask

  task automatic send_frame(input logic [7:0] b);
    @(negedge clk); rx = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  task automatic drain();
    wait (expq.size() == 0);
    repeat (80) @(negedge clk);
  endtask

  initial begin
    logic [7:0] b;
    logic [7:0] e;
    wait (rst_n);
    forever begin
      @(negedge tx);
      repeat (BIT / 2) @(posedge clk);
      #1 chk("R2 start bit", {31'd0, tx}, 32'd0);
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(posedge clk);
        #1 b[i] = tx;
      end
      repeat (BIT) @(posedge clk);
      #1 chk("R2 stop bit", {31'd0, tx}, 32'd1);
      if (two_stop) begin
        repeat (BIT) @(posedge clk);
        #1 chk("R4 second stop bit", {31'd0, tx}, 32'd1);
      end
      if (expq.size() == 0) begin
        chk("R3 unexpected frame", {24'd0, b}, 32'hFFFF_FFFF);
      end else begin
        e = expq.pop_front();
        chk("R2 tx byte", {24'd0, b}, {24'd0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 chk("R1 tx idle", {31'd0, tx}, 32'd1);
    chk("R1 irq low", {31'd0, irq}, 32'd0);
    rd(3'd2, d); chk("R1 tx ctrl", d, 32'd0);
    rd(3'd3, d); chk("R1 rx ctrl", d, 32'd0);
    rd(3'd4, d); chk("R1 irq enable", d, 32'd0);
    rd(3'd1, d); chk("R1 rx empty", d, 32'h8000_0000);

    wr(3'd6, 32'd3);
    rd(3'd6, d); chk("R9 divisor readback", d, 32'd3);
    wr(3'd2, 32'h1);
    put_tx(8'hA5, 1); put_tx(8'h3C, 1); put_tx(8'h01, 1);
    drain();
    chk("R2 all sent", expq.size(), 32'd0);

    wr(3'd2, 32'h0);
    for (int i = 0; i < 9; i++) put_tx(8'h80 + 8'(i), i < 8);
    rd(3'd0, d); chk("R3 full flag", d, 32'h8000_0000);
    repeat (60) @(negedge clk);
    chk("R3 held while disabled", {31'd0, tx}, 32'd1);
    two_stop = 1'b1;
    wr(3'd2, 32'h3);
    rd(3'd2, d); chk("R9 tx ctrl readback", d, 32'h3);
    drain();
    rd(3'd0, d); chk("R3 not full after drain", d, 32'd0);
    two_stop = 1'b0;

    wr(3'd2, 32'h0002_0000);
    rd(3'd5, d); chk("R7 tx pending below wm", d, 32'd1);
    put_tx(8'h5A, 1); put_tx(8'hC3, 1);
    rd(3'd5, d); chk("R7 tx pending at wm", d, 32'd0);
    wr(3'd4, 32'd1);
    #1 chk("R7 irq off at wm", {31'd0, irq}, 32'd0);
    wr(3'd2, 32'h0002_0001);
    drain();
    chk("R7 irq tx below wm", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'd0);
    wr(3'd2, 32'h0);

    wr(3'd3, 32'h1);
    send_frame(8'hA5);
    rd(3'd5, d); chk("R7 rx pending wm0", d, 32'd2);
    rd(3'd1, d); chk("R5 rx byte", d, 32'h0000_00A5);
    rd(3'd1, d); chk("R5 empty read", d, 32'h8000_0000);
    rd(3'd5, d); chk("R7 rx pending cleared", d, 32'd0);

    wr(3'd3, 32'h0002_0001);
    rd(3'd3, d); chk("R9 rx ctrl readback", d, 32'h0002_0001);
    wr(3'd4, 32'd2);
    send_frame(8'h11); send_frame(8'h22);
    rd(3'd5, d); chk("R7 rx at wm", d, 32'd0);
    chk("R7 irq off rx at wm", {31'd0, irq}, 32'd0);
    send_frame(8'h33);
    rd(3'd5, d); chk("R7 rx above wm", d, 32'd2);
    chk("R7 irq rx above wm", {31'd0, irq}, 32'd1);
    rd(3'd1, d); chk("R5 order 1", d, 32'h11);
    rd(3'd1, d); chk("R5 order 2", d, 32'h22);
    rd(3'd1, d); chk("R5 order 3", d, 32'h33);
    wr(3'd4, 32'd0);

    wr(3'd3, 32'h1);
    for (int i = 0; i < 9; i++) send_frame(8'h40 + 8'(i));
    for (int i = 0; i < 8; i++) begin
      rd(3'd1, d); chk("R6 stored byte", d, 32'h40 + i);
    end
    rd(3'd1, d); chk("R6 extra byte dropped", d, 32'h8000_0000);

    @(negedge clk); rx = 1'b0;
    @(negedge clk); rx = 1'b1;
    repeat (60) @(negedge clk);
    rd(3'd1, d); chk("R8 glitch rejected", d, 32'h8000_0000);

    wr(3'd3, 32'h0);
    send_frame(8'h77);
    rd(3'd1, d); chk("R9 rx disabled ignores", d, 32'h8000_0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule